// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Error Status

This block buffers characters coming out of a serial receive engine until a processor reads them. Three characters are stored in arrival order. Each one carries its own parity-error, framing-error and break bit. A one-character hold stage sits in front of the storage and plays the part of the receiver's assembly register. It absorbs a fourth character while the storage is full, so four characters can be outstanding before anything is lost.

The read side sees three things: a ready indication, the oldest stored character, and three status bits. A mode input chooses what the status bits mean. In character mode they belong to the oldest stored character. In block mode they are the OR of every character completed since the last error-clear. A single sticky overrun bit records that a waiting character was overwritten. It is kept apart from the stored characters and cleared only by the error-clear input.

The receive engine offers a finished character with a one-cycle `push_valid` strobe. The reader removes the head character with a one-cycle `pop` strobe once it has used the data.

Top module: `rx_status_fifo`

## Requirements
- R1: Characters are read out in the order they were completed. `rd_data` shows the oldest stored character, and a `pop` strobe removes it so the next one appears in the following cycle.
- R2: Each stored character keeps its own parity, framing and break bits. In character mode (`block_mode`=0), `rd_par`, `rd_frm` and `rd_brk` are the bits of the character currently on `rd_data`.
- R3: `rd_ready` is 1 exactly when at least one character is stored. `rd_full` is 1 exactly when all three storage slots are occupied.
- R4: A character completed while storage is full waits in the hold stage. It moves into storage in the same cycle that a pop frees a slot, so four characters pushed in a row are all read back in order.
- R5: If a character completes while storage is full and the hold stage is occupied, `overrun` is set to 1. The new character replaces the waiting one, and the replaced character is never read.
- R6: `overrun` stays at 1 until `err_clear` is pulsed. If `err_clear` and a new overrun happen in the same cycle, `overrun` is 1 afterwards.
- R7: In block mode (`block_mode`=1), each status output is the OR of that bit over every character completed since the last `err_clear`. This includes characters that have since been read. `err_clear` leaves the stored characters and `rd_ready`/`rd_full` unchanged.
- R8: While storage is empty, `rd_data` and the character-mode status read 0. A `pop` while empty changes nothing, so the next character pushed is the only one read back.
- R9: A push and a pop in the same cycle with one character stored leave exactly one character stored: the newly pushed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | One-cycle strobe: a character has been completed |
| push_data | input | DATA_W | Completed character |
| push_par | input | 1 | Parity error of the completed character |
| push_frm | input | 1 | Framing error of the completed character |
| push_brk | input | 1 | Break indication of the completed character |
| pop | input | 1 | One-cycle strobe: remove the head character |
| err_clear | input | 1 | Clears overrun and the block-mode accumulated status |
| block_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| rd_ready | output | 1 | At least one character stored |
| rd_full | output | 1 | All storage slots occupied |
| rd_data | output | DATA_W | Head character, 0 when empty |
| rd_par | output | 1 | Parity error status per selected mode |
| rd_frm | output | 1 | Framing error status per selected mode |
| rd_brk | output | 1 | Break status per selected mode |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is the one where storage is full, the hold stage is occupied, and a further character arrives. Only that combination overwrites data and raises overrun, and the same state must also be combined with an error-clear in the same cycle. The bench gets there by pushing five characters back to back with no pops, and then by refilling to the same point before issuing a push and an error-clear together. Draining afterwards shows at the ports which character survived the overwrite, and shows that the hold stage moved into storage as pops freed slots.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic par;
    logic frm;
    logic brk;
  } rxq_flags_t;

  localparam int FLAG_W = 3;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  rxq_flags_t                    wr_flags,
  input  logic                          rd_en,
  output logic [DATA_W-1:0]             head_data,
  output rxq_flags_t                    head_flags,
  output logic [$clog2(DEPTH+1)-1:0]    count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] data_mem [DEPTH];
  rxq_flags_t        flag_mem [DEPTH];

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  // storage array kept without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_ptr_q] <= wr_data;
      flag_mem[wr_ptr_q] <= wr_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (rd_en) rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_comb begin
    if (count_q != '0) begin
      head_data  = data_mem[rd_ptr_q];
      head_flags = flag_mem[rd_ptr_q];
    end else begin
      head_data  = '0;
      head_flags = '0;
    end
  end

  assign count = count_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_CNT); // R3

  AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count_q != '0); // R8

  AST_NO_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (count_q == FULL_CNT && !rd_en) |-> !wr_en); // R4

  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> count_q == $past(count_q) - CNT_W'(1)); // R1

endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push_valid,
  input  logic [DATA_W-1:0]             push_data,
  input  rxq_flags_t                    push_flags,
  input  logic                          pop_req,
  input  logic [$clog2(DEPTH+1)-1:0]    fifo_count,
  output logic                          pop_ok,
  output logic                          fifo_wr_en,
  output logic [DATA_W-1:0]             fifo_wr_data,
  output rxq_flags_t                    fifo_wr_flags,
  output logic                          ovr_set
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic              hold_v_q;
  logic [DATA_W-1:0] hold_data_q;
  rxq_flags_t        hold_flags_q;

  logic [CNT_W-1:0] cnt_after_pop;
  logic             room;
  logic             hold_move;
  logic             to_hold;

  always_comb begin
    pop_ok        = pop_req && (fifo_count != '0);
    cnt_after_pop = fifo_count - {{(CNT_W-1){1'b0}}, pop_ok};
    room          = cnt_after_pop < FULL_CNT;
    hold_move     = hold_v_q && room;
    to_hold       = push_valid && (hold_v_q || !room);
    ovr_set       = push_valid && hold_v_q && !room;
    fifo_wr_en    = hold_move || (push_valid && room && !hold_v_q);
    fifo_wr_data  = hold_move ? hold_data_q  : push_data;
    fifo_wr_flags = hold_move ? hold_flags_q : push_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v_q <= 1'b0;
    end else if (to_hold) begin
      hold_v_q <= 1'b1;
    end else if (hold_move) begin
      hold_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (to_hold) begin
      hold_data_q  <= push_data;
      hold_flags_q <= push_flags;
    end
  end

  AST_HOLD_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    hold_v_q |-> fifo_count == FULL_CNT); // R4

  AST_HOLD_DRAINS_ON_POP: assert property (@(posedge clk) disable iff (rst)
    (hold_v_q && pop_ok) |-> fifo_wr_en); // R4

  AST_OVR_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    ovr_set |-> (hold_v_q && fifo_count == FULL_CNT)); // R5

endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       block_mode,
  input  logic       err_clear,
  input  logic       new_valid,
  input  rxq_flags_t new_flags,
  input  rxq_flags_t head_flags,
  input  logic       ovr_set,
  output rxq_flags_t shown_flags,
  output logic       overrun
);

  rxq_flags_t acc_q;
  logic       ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= (err_clear ? '0 : acc_q) | (new_valid ? new_flags : '0);
      ovr_q <= (ovr_q && !err_clear) || ovr_set;
    end
  end

  assign shown_flags = block_mode ? acc_q : head_flags;
  assign overrun     = ovr_q;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !err_clear) |=> ovr_q); // R6

  AST_OVR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ovr_set |=> ovr_q); // R6

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (err_clear && !new_valid) |=> acc_q == '0); // R7

  AST_ACC_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !err_clear |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R7

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_par,
  input  logic              push_frm,
  input  logic              push_brk,
  input  logic              pop,
  input  logic              err_clear,
  input  logic              block_mode,
  output logic              rd_ready,
  output logic              rd_full,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_par,
  output logic              rd_frm,
  output logic              rd_brk,
  output logic              overrun
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rxq_flags_t        in_flags;
  rxq_flags_t        wr_flags;
  rxq_flags_t        head_flags;
  rxq_flags_t        shown_flags;
  logic [DATA_W-1:0] wr_data;
  logic              wr_en;
  logic              pop_ok;
  logic              ovr_set;
  logic [CNT_W-1:0]  count;

  assign in_flags = '{par: push_par, frm: push_frm, brk: push_brk};

  rxq_hold #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hold (
    .clk           (clk),
    .rst           (rst),
    .push_valid    (push_valid),
    .push_data     (push_data),
    .push_flags    (in_flags),
    .pop_req       (pop),
    .fifo_count    (count),
    .pop_ok        (pop_ok),
    .fifo_wr_en    (wr_en),
    .fifo_wr_data  (wr_data),
    .fifo_wr_flags (wr_flags),
    .ovr_set       (ovr_set)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_flags   (wr_flags),
    .rd_en      (pop_ok),
    .head_data  (rd_data),
    .head_flags (head_flags),
    .count      (count)
  );

  rxq_status u_status (
    .clk         (clk),
    .rst         (rst),
    .block_mode  (block_mode),
    .err_clear   (err_clear),
    .new_valid   (push_valid),
    .new_flags   (in_flags),
    .head_flags  (head_flags),
    .ovr_set     (ovr_set),
    .shown_flags (shown_flags),
    .overrun     (overrun)
  );

  assign rd_ready = (count != '0);
  assign rd_full  = (count == FULL_CNT);
  assign rd_par   = shown_flags.par;
  assign rd_frm   = shown_flags.frm;
  assign rd_brk   = shown_flags.brk;

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_ready |-> rd_data == '0); // R8

  AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (rst)
    rd_full |-> rd_ready); // R3

  AST_CLEAR_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (err_clear && !push_valid && !pop) |=> $stable(count)); // R7

endmodule

// File: tb/rx_status_fifo_tb.sv
module rx_status_fifo_tb;

  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              push_valid = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic              push_par = 1'b0, push_frm = 1'b0, push_brk = 1'b0;
  logic              pop = 1'b0, err_clear = 1'b0, block_mode = 1'b0;
  logic              rd_ready, rd_full, rd_par, rd_frm, rd_brk, overrun;
  logic [DATA_W-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_status_fifo #(.DATA_W(DATA_W), .DEPTH(3)) u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .push_par(push_par), .push_frm(push_frm), .push_brk(push_brk),
    .pop(pop), .err_clear(err_clear), .block_mode(block_mode),
    .rd_ready(rd_ready), .rd_full(rd_full), .rd_data(rd_data),
    .rd_par(rd_par), .rd_frm(rd_frm), .rd_brk(rd_brk), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at the falling edge
  task automatic cyc(input bit pv, input logic [7:0] d, input logic [2:0] f,
                     input bit pp, input bit ec);
    push_valid = pv; push_data = d;
    {push_par, push_frm, push_brk} = f;
    pop = pp; err_clear = ec;
    @(negedge clk);
    push_valid = 1'b0; pop = 1'b0; err_clear = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    cyc(1'b1, d, f, 1'b0, 1'b0);
  endtask

  // check head character and its status, then remove it
  task automatic read_expect(input string req, input logic [7:0] d, input logic [2:0] f);
    chk(req, {31'd0, rd_ready}, 32'd1);
    chk(req, {24'd0, rd_data}, {24'd0, d});
    if (!block_mode) chk(req, {29'd0, rd_par, rd_frm, rd_brk}, {29'd0, f});
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    chk("R3 ready after reset", {31'd0, rd_ready}, 32'd0);
    chk("R3 full after reset", {31'd0, rd_full}, 32'd0);
    chk("R8 data zero when empty", {24'd0, rd_data}, 32'd0);
    chk("R8 status zero when empty", {29'd0, rd_par, rd_frm, rd_brk}, 32'd0);
    chk("R6 overrun after reset", {31'd0, overrun}, 32'd0);
  endtask

  task automatic t_order;
    do_reset();
    push(8'h11, 3'b100);
    chk("R3 ready with one", {31'd0, rd_ready}, 32'd1);
    push(8'h22, 3'b010);
    chk("R3 not full with two", {31'd0, rd_full}, 32'd0);
    push(8'h33, 3'b001);
    chk("R3 full with three", {31'd0, rd_full}, 32'd1);
    read_expect("R1 R2 first", 8'h11, 3'b100);
    chk("R3 full drops", {31'd0, rd_full}, 32'd0);
    read_expect("R1 R2 second", 8'h22, 3'b010);
    read_expect("R1 R2 third", 8'h33, 3'b001);
    chk("R3 ready drops", {31'd0, rd_ready}, 32'd0);
  endtask

  task automatic t_hold;
    do_reset();
    for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i), 3'(i));
    chk("R4 full with hold", {31'd0, rd_full}, 32'd1);
    chk("R4 no overrun", {31'd0, overrun}, 32'd0);
    for (int i = 0; i < 4; i++) read_expect("R4 drain", 8'hA0 + 8'(i), 3'(i));
    chk("R4 empty after four", {31'd0, rd_ready}, 32'd0);
  endtask

  task automatic t_overrun;
    do_reset();
    for (int i = 0; i < 5; i++) push(8'hB0 + 8'(i), 3'b000);
    chk("R5 overrun set", {31'd0, overrun}, 32'd1);
    read_expect("R5 keep first", 8'hB0, 3'b000);
    chk("R6 overrun sticky", {31'd0, overrun}, 32'd1);
    cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    chk("R6 overrun cleared", {31'd0, overrun}, 32'd0);
    chk("R7 clear keeps level", {31'd0, rd_full}, 32'd1);
    read_expect("R7 clear keeps data", 8'hB1, 3'b000);
    read_expect("R5 third", 8'hB2, 3'b000);
    read_expect("R5 newest replaces", 8'hB4, 3'b000);
    chk("R5 replaced one gone", {31'd0, rd_ready}, 32'd0);
  endtask

  task automatic t_set_wins;
    do_reset();
    for (int i = 0; i < 4; i++) push(8'hC0 + 8'(i), 3'b000);
    cyc(1'b1, 8'hC9, 3'b000, 1'b0, 1'b1);
    chk("R6 set wins over clear", {31'd0, overrun}, 32'd1);
  endtask

  task automatic t_block;
    do_reset();
    block_mode = 1'b1;
    push(8'h01, 3'b100);
    push(8'h02, 3'b010);
    chk("R7 block or", {29'd0, rd_par, rd_frm, rd_brk}, 32'd6);
    read_expect("R7 block read", 8'h01, 3'b000);
    read_expect("R7 block read", 8'h02, 3'b000);
    chk("R7 block after reads", {29'd0, rd_par, rd_frm, rd_brk}, 32'd6);
    cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    chk("R7 block cleared", {29'd0, rd_par, rd_frm, rd_brk}, 32'd0);
    push(8'h03, 3'b001);
    block_mode = 1'b0;
    chk("R2 char mode head", {29'd0, rd_par, rd_frm, rd_brk}, 32'd1);
    block_mode = 1'b1;
    chk("R7 block new", {29'd0, rd_par, rd_frm, rd_brk}, 32'd1);
    block_mode = 1'b0;
  endtask

  task automatic t_empty_pop;
    do_reset();
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    chk("R8 pop empty", {31'd0, rd_ready}, 32'd0);
    push(8'h5A, 3'b010);
    read_expect("R8 after empty pop", 8'h5A, 3'b010);
    chk("R8 single entry", {31'd0, rd_ready}, 32'd0);
  endtask

  task automatic t_simul;
    do_reset();
    push(8'h71, 3'b000);
    cyc(1'b1, 8'h72, 3'b100, 1'b1, 1'b0);
    read_expect("R9 new char remains", 8'h72, 3'b100);
    chk("R9 exactly one", {31'd0, rd_ready}, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_hold();
    t_overrun();
    t_set_wins();
    t_block();
    t_empty_pop();
    t_simul();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule